// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by reading a two-level page table from memory. The processor side offers a request made of a virtual address, an access-type mask and a table base register. Once the block accepts the request it runs one walk.

The walk reads one entry from the top table. If that entry is valid, it reads one entry from the second-level table the entry points to. It then returns a one-cycle response. The response carries the physical address, a fault code and the rights bits of the last entry it read.

Memory is reached through a single-word read port. The memory may answer after any number of cycles. Only one walk is ever in flight.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, reqReady is 1 and both rspValid and memReqValid are 0.
- R2: The first memory read of a walk uses address baseReg + 4 * vaddr[31:22].
- R3: The second read uses address ({topEntry[31:12], 12'h000}) + 4 * vaddr[21:12], where topEntry is the word returned by the first read.
- R4: A successful walk returns rspFault = 2'b00 and rspPaddr = {leafEntry[31:12], vaddr[11:0]}.
- R5: A top entry whose bit 0 (valid) is 0 ends the walk after that single read. The response has rspFault = 2'b01 (page fault) and rspPaddr = 0.
- R6: A leaf entry whose bit 0 is 0 gives rspFault = 2'b01 and rspPaddr = 0, whatever the access mask.
- R7: reqAccess uses bit 0 for read, bit 1 for write and bit 2 for execute. These are matched against the leaf rights: bit 1 read, bit 2 write, bit 3 execute. If the leaf is valid and any requested type is not granted, the response has rspFault = 2'b10 (protection fault) and rspPaddr = 0. An empty mask always passes.
- R8: rspRights carries bits 3:1 of the last entry read, in the order {execute, write, read}.
- R9: reqReady is 0 from the cycle after a request is accepted until the response has been given. Requests presented in that window are ignored and start no walk.
- R10: rspValid is high for exactly one cycle per walk. While memReqValid waits for memRspValid, memAddr holds steady.
- R11: The walk waits for as many cycles as memory takes to raise memRspValid. The result does not depend on that latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 3 | Requested access types {exec, write, read} |
| baseReg | input | 32 | Physical address of the top-level table |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | 32 | Physical address, zero on any fault |
| rspFault | output | 2 | 00 none, 01 page fault, 10 protection fault |
| rspRights | output | 3 | Rights bits of the last entry read |
| memReqValid | output | 1 | Memory word read requested |
| memAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Memory read data valid |
| memData | input | 32 | Entry word returned by memory |

## Verification
The hardest case to reach from the ports is a second request arriving while a walk is still waiting on a slow memory. The walk must neither take the new address nor restart once it finishes. The bench slows its memory model to several cycles per read and holds a different request on the input for part of the walk. It then checks that the response belongs to the first address and that no further memory read follows. The table walk also runs at memory latencies of zero to two cycles, so that each state exit is reached on both fast and slow responses.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int RIGHTS_W   = 3;
  localparam int RIGHTS_LSB = 1;
  localparam int ENTRY_SHIFT = 2;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ_L1,
    ST_READ_L2,
    ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic capture;
    logic takeTop;
    logic takeLeaf;
    logic selLeaf;
  } walk_ctl_t;

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      memReqValid,
  input  logic      memRspValid,
  input  logic      entryValid,
  output logic      rspValid,
  output walk_ctl_t ctl
);

  walk_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capture = 1'b1;
          nextState   = ST_READ_L1;
        end
      end
      ST_READ_L1: begin
        if (memRspValid) begin
          ctl.takeTop = 1'b1;
          nextState   = entryValid ? ST_READ_L2 : ST_DONE;
        end
      end
      ST_READ_L2: begin
        ctl.selLeaf = 1'b1;
        if (memRspValid) begin
          ctl.takeLeaf = 1'b1;
          nextState    = ST_DONE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_READ_L1) || (state == ST_READ_L2);
  assign rspValid    = (state == ST_DONE);

  // R11: a read state is held for as long as memory has not answered
  assert_wait_top_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ_L1 && !memRspValid) |=> (state == ST_READ_L1));
  assert_wait_leaf_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ_L2 && !memRspValid) |=> (state == ST_READ_L2));
  // R5: an invalid top entry skips the second read
  assert_top_fault_skip_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ_L1 && memRspValid && !entryValid) |=> (state == ST_DONE));

endmodule

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  walk_ctl_t           ctl,
  input  logic [OFF_W+2*IDX_W-1:0] reqVaddr,
  input  logic [RIGHTS_W-1:0] reqAccess,
  input  logic [OFF_W+2*IDX_W-1:0] baseReg,
  input  logic [OFF_W+2*IDX_W-1:0] memData,
  output logic [OFF_W+2*IDX_W-1:0] memAddr,
  output logic                entryValid,
  output logic [OFF_W+2*IDX_W-1:0] rspPaddr,
  output logic [1:0]          rspFault,
  output logic [RIGHTS_W-1:0] rspRights
);

  localparam int ADDR_W = OFF_W + 2 * IDX_W;
  localparam int PFN_W  = ADDR_W - OFF_W;
  localparam int LEVELS = 2;

  logic [ADDR_W-1:0]   vaReg, baseR, leafBase, paddrR;
  logic [RIGHTS_W-1:0] accReg, rightsR, entryRights;
  fault_e              faultR;
  logic [IDX_W-1:0]    levelIdx [LEVELS];
  logic [ADDR_W-1:0]   tableBase, entryOffset;

  // level 0 is the top table (upper bits), level 1 the leaf table
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_index
    assign levelIdx[lv] = vaReg[OFF_W + (LEVELS-1-lv)*IDX_W +: IDX_W];
  end

  assign tableBase   = ctl.selLeaf ? leafBase : baseR;
  assign entryOffset = {{(ADDR_W-IDX_W-ENTRY_SHIFT){1'b0}},
                        (ctl.selLeaf ? levelIdx[1] : levelIdx[0]),
                        {ENTRY_SHIFT{1'b0}}};
  assign memAddr     = tableBase + entryOffset;

  assign entryValid  = memData[0];
  assign entryRights = memData[RIGHTS_LSB +: RIGHTS_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      baseR    <= '0;
      accReg   <= '0;
      leafBase <= '0;
      paddrR   <= '0;
      rightsR  <= '0;
      faultR   <= FLT_NONE;
    end else begin
      if (ctl.capture) begin
        vaReg   <= reqVaddr;
        baseR   <= baseReg;
        accReg  <= reqAccess;
        paddrR  <= '0;
        rightsR <= '0;
        faultR  <= FLT_NONE;
      end
      if (ctl.takeTop) begin
        rightsR  <= entryRights;
        leafBase <= {memData[ADDR_W-1 -: PFN_W], {OFF_W{1'b0}}};
        if (!entryValid) faultR <= FLT_PAGE;
      end
      if (ctl.takeLeaf) begin
        rightsR <= entryRights;
        if (!entryValid)
          faultR <= FLT_PAGE;
        else if ((accReg & ~entryRights) != '0)
          faultR <= FLT_PROT;
        else
          paddrR <= {memData[ADDR_W-1 -: PFN_W], vaReg[OFF_W-1:0]};
      end
    end
  end

  assign rspPaddr  = paddrR;
  assign rspFault  = faultR;
  assign rspRights = rightsR;

  // R4: a clean leaf result keeps the page offset of the request
  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.takeLeaf) && faultR == FLT_NONE)
      |-> (paddrR[OFF_W-1:0] == vaReg[OFF_W-1:0]));
  // R7: a protection fault only when some requested type lacks a right
  assert_prot_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.takeLeaf) && faultR == FLT_PROT)
      |-> ((accReg & ~rightsR) != '0));

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [OFF_W+2*IDX_W-1:0]  reqVaddr,
  input  logic [RIGHTS_W-1:0]       reqAccess,
  input  logic [OFF_W+2*IDX_W-1:0]  baseReg,
  output logic                      rspValid,
  output logic [OFF_W+2*IDX_W-1:0]  rspPaddr,
  output logic [1:0]                rspFault,
  output logic [RIGHTS_W-1:0]       rspRights,
  output logic                      memReqValid,
  output logic [OFF_W+2*IDX_W-1:0]  memAddr,
  input  logic                      memRspValid,
  input  logic [OFF_W+2*IDX_W-1:0]  memData
);

  walk_ctl_t ctl;
  logic      entryValid;

  pgwalk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memRspValid (memRspValid),
    .entryValid  (entryValid),
    .rspValid    (rspValid),
    .ctl         (ctl)
  );

  pgwalk_dp #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqVaddr   (reqVaddr),
    .reqAccess  (reqAccess),
    .baseReg    (baseReg),
    .memData    (memData),
    .memAddr    (memAddr),
    .entryValid (entryValid),
    .rspPaddr   (rspPaddr),
    .rspFault   (rspFault),
    .rspRights  (rspRights)
  );

  // R9: acceptance closes the request port for the walk
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && !rspValid));
  // R10: response lasts one cycle and then the walker is idle
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));
  // R10: address held while memory is pending
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> (memReqValid && $stable(memAddr)));
  // R5: faulted responses carry no address
  assert_fault_no_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'b00) |-> (rspPaddr == '0));
  // R1: idle walker issues no memory read
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReqValid && !rspValid));

endmodule

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;

  typedef struct packed {
    logic [31:0] va;
    logic [2:0]  acc;
    logic [31:0] pa;
    logic [1:0]  flt;
    logic [2:0]  rts;
    logic [1:0]  reads;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0040_5123, 3'd1, 32'hABCD_E123, 2'd0, 3'd7, 2'd2},
    '{32'h0040_5456, 3'd6, 32'hABCD_E456, 2'd0, 3'd7, 2'd2},
    '{32'h0040_7FFF, 3'd4, 32'h5555_5FFF, 2'd0, 3'd5, 2'd2},
    '{32'h0040_7010, 3'd2, 32'h0000_0000, 2'd2, 3'd5, 2'd2},
    '{32'h0040_6000, 3'd1, 32'h0000_0000, 2'd1, 3'd7, 2'd2},
    '{32'h00C0_1000, 3'd1, 32'h0000_0000, 2'd1, 3'd0, 2'd1},
    '{32'h0080_0800, 3'd1, 32'h7777_7800, 2'd0, 3'd1, 2'd2},
    '{32'h0080_0ABC, 3'd3, 32'h0000_0000, 2'd2, 3'd1, 2'd2},
    '{32'h0040_5000, 3'd0, 32'hABCD_E000, 2'd0, 3'd7, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [2:0]  reqAccess = '0;
  logic [31:0] baseReg = '0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic [1:0]  rspFault;
  logic [2:0]  rspRights;
  logic        memReqValid;
  logic [31:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memData = '0;

  int checks = 0;
  int failures = 0;
  int memLat = 0;
  int waitCnt = 0;
  int nReads = 0;
  int unstable = 0;
  logic [31:0] firstAddr = '0;
  logic [31:0] addrLog [4];
  logic [31:0] mem [256];

  always #10 clk = ~clk;

  pgwalk_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .baseReg(baseReg),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault),
    .rspRights(rspRights), .memReqValid(memReqValid), .memAddr(memAddr),
    .memRspValid(memRspValid), .memData(memData)
  );

  function automatic int memIdx(input logic [31:0] a);
    return int'({a[13:12], a[7:2]});
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: answers memLat cycles after a request is seen
  initial begin
    forever begin
      @(negedge clk);
      if (memRspValid) begin
        memRspValid = 1'b0;
        waitCnt = 0;
      end else if (memReqValid) begin
        if (waitCnt == 0) firstAddr = memAddr;
        else if (memAddr != firstAddr) unstable++;
        if (waitCnt >= memLat) begin
          memRspValid = 1'b1;
          memData = mem[memIdx(memAddr)];
          if (nReads < 4) addrLog[nReads] = memAddr;
          nReads++;
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic doWalk(input logic [31:0] va, input logic [2:0] acc,
                        input logic [31:0] base, output bit done);
    int guard;
    @(negedge clk);
    nReads = 0;
    unstable = 0;
    reqVaddr = va;
    reqAccess = acc;
    baseReg = base;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    guard = 0;
    while (!rspValid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    done = rspValid;
  endtask

  task automatic runVec(input vec_t v, input logic [31:0] base, input string tag);
    bit done;
    logic [31:0] a1, a2, top;
    doWalk(v.va, v.acc, base, done);
    chk(done, "R11", {tag, " response seen"}, 32'(done), 32'd1);
    chk(rspPaddr == v.pa, (v.flt == 0) ? "R4" : "R5", {tag, " paddr"}, rspPaddr, v.pa);
    chk(rspFault == v.flt, (v.flt == 2) ? "R7" : "R6", {tag, " fault"}, 32'(rspFault), 32'(v.flt));
    chk(rspRights == v.rts, "R8", {tag, " rights"}, 32'(rspRights), 32'(v.rts));
    chk(nReads == int'(v.reads), "R5", {tag, " read count"}, 32'(nReads), 32'(v.reads));
    a1 = base + {20'h0, v.va[31:22], 2'b00};
    chk(addrLog[0] == a1, "R2", {tag, " top address"}, addrLog[0], a1);
    if (v.reads == 2) begin
      top = mem[memIdx(a1)];
      a2 = {top[31:12], 12'h000} + {20'h0, v.va[21:12], 2'b00};
      chk(addrLog[1] == a2, "R3", {tag, " leaf address"}, addrLog[1], a2);
    end
    chk(unstable == 0, "R10", {tag, " address held"}, 32'(unstable), 32'd0);
    @(negedge clk);
    chk(!rspValid, "R10", {tag, " single-cycle response"}, 32'(rspValid), 32'd0);
  endtask

  initial begin
    bit done;
    foreach (mem[k]) mem[k] = 32'h0;
    // top table at 0x0000
    mem[memIdx(32'h0000_0004)] = 32'h0000_100F;
    mem[memIdx(32'h0000_0008)] = 32'h0000_2003;
    mem[memIdx(32'h0000_000C)] = 32'h0000_0000;
    // second-level table at 0x1000
    mem[memIdx(32'h0000_1014)] = 32'hABCD_E00F;
    mem[memIdx(32'h0000_1018)] = 32'h1234_500E;
    mem[memIdx(32'h0000_101C)] = 32'h5555_500B;
    // second-level table at 0x2000
    mem[memIdx(32'h0000_2000)] = 32'h7777_7003;
    // alternate top table at 0x3000
    mem[memIdx(32'h0000_3000)] = 32'h0000_100F;

    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reset reqReady", 32'(reqReady), 32'd1);
    chk(rspValid == 1'b0, "R1", "reset rspValid", 32'(rspValid), 32'd0);
    chk(memReqValid == 1'b0, "R1", "reset memReqValid", 32'(memReqValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "idle after reset", 32'(reqReady), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      memLat = i % 3;
      runVec(VECS[i], 32'h0, $sformatf("vec%0d", i));
    end

    // R2: a different table base register
    memLat = 1;
    runVec('{32'h0000_5001, 3'd5, 32'hABCD_E001, 2'd0, 3'd7, 2'd2},
           32'h0000_3000, "alt base");

    // R9: a second request during a slow walk is ignored
    memLat = 4;
    @(negedge clk);
    nReads = 0;
    reqVaddr = 32'h0040_5123;
    reqAccess = 3'd1;
    baseReg = 32'h0;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqVaddr = 32'h0040_7FFF;
    reqAccess = 3'd4;
    for (int c = 0; c < 3; c++) begin
      chk(reqReady == 1'b0, "R9", "busy during walk", 32'(reqReady), 32'd0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    begin
      int guard = 0;
      while (!rspValid && guard < 200) begin
        @(negedge clk);
        guard++;
      end
    end
    chk(rspPaddr == 32'hABCD_E123, "R9", "first request kept", rspPaddr, 32'hABCD_E123);
    chk(nReads == 2, "R9", "reads of busy walk", 32'(nReads), 32'd2);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(memReqValid == 1'b0, "R9", "no walk after ignored request", 32'(memReqValid), 32'd0);
    end
    chk(reqReady == 1'b1, "R9", "idle after walk", 32'(reqReady), 32'd1);

    // R11: long latency does not change the result
    memLat = 7;
    doWalk(32'h0080_0800, 3'd1, 32'h0, done);
    chk(done && rspPaddr == 32'h7777_7800, "R11", "slow memory result", rspPaddr, 32'h7777_7800);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule